// File: doc/BRIEF.md
# I2C Slave Controller with Overflow-Aware Acknowledge

This block is the target side of a Standard-mode I2C bus. It watches the SCL and SDA lines, which are re-timed to the system clock, and finds Start and Stop conditions. It compares the first byte after a Start with its own 7-bit or 10-bit address. Matched address bytes and the data bytes that follow are acknowledged, shifted in most significant bit first, and copied into a receive register that the host reads. The block can also act as a slave transmitter. In that case it holds SCL low until the host has supplied the next byte, then shifts that byte out on SDA.

The host sees a buffer-full flag, a sticky overflow flag, an address/data flag, Start and Stop status bits and one interrupt line. A received byte gets no acknowledge while the buffer-full or overflow flag is still set. That byte is discarded, but the interrupt is still raised, so firmware always learns that traffic arrived. One mode raises interrupts only on Start and Stop, with the slave logic idle, so that firmware can drive a bus as master.

Top module: `i2c_slv`

## Requirements
- R1: After reset, all status outputs (buf_full, ovf, data_flag, start_flag, stop_flag, irq) are 0, and neither scl_oe nor sda_oe is asserted.
- R2: A fall of SDA while SCL is high sets start_flag and clears stop_flag. A rise of SDA while SCL is high sets stop_flag and clears start_flag.
- R3: The mode field selects the behaviour. 4'b0110 is the 7-bit slave and 4'b0111 is the 10-bit slave. 4'b1110 and 4'b1111 are the same two slaves with Start/Stop interrupts. 4'b1011 gives Start/Stop interrupts only. A Start or Stop raises irq only in 4'b1110, 4'b1111 and 4'b1011.
- R4: In 7-bit modes, the block acknowledges an address byte {own_addr[6:0], rw} with rw=0, loads it into rx_data, sets buf_full and irq, and clears data_flag.
- R5: The block acknowledges each data byte after a matched write address and loads it MSB-first into rx_data. It sets buf_full, data_flag and irq, and buf_full clears on an rd_buf pulse.
- R6: If buf_full is already set when a byte completes, the block sends no acknowledge and leaves rx_data unchanged. It sets irq and sets ovf.
- R7: If ovf is set when a byte completes, the block sends no acknowledge and leaves rx_data and buf_full unchanged, but it still sets irq. Reading the buffer does not clear ovf; only an ovf_clr pulse does.
- R8: An address byte that differs from the own address is not acknowledged and raises no irq. The general call byte 0x00 is never acknowledged.
- R9: In 10-bit modes, the first byte must be 11110 followed by own_addr[9:8] and rw=0, and the second byte must equal own_addr[7:0]. Each matching byte is acknowledged and loaded. A mismatching second byte gets no acknowledge.
- R10: When a read address is acknowledged, the block holds SCL low (scl_oe) and raises irq. Once irq is cleared it drives tx_data MSB-first. A master acknowledge repeats the hold for the next byte. A master no-acknowledge leaves SDA released until the next Start or Stop.
- R11: In mode 4'b1011, no address byte is acknowledged and nothing is loaded.
- R12: While en is 0, the block acknowledges nothing, releases both lines and leaves start_flag, stop_flag and irq unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Module enable |
| mode | input | 4 | Operating mode select |
| own_addr | input | 10 | Own slave address (7-bit modes use bits 6:0) |
| tx_data | input | 8 | Byte to transmit, sampled when the SCL hold ends |
| rd_buf | input | 1 | Host read strobe, clears buf_full |
| ovf_clr | input | 1 | Host strobe clearing ovf |
| irq_clr | input | 1 | Host strobe clearing irq |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| rx_data | output | 8 | Receive buffer |
| buf_full | output | 1 | Receive buffer holds an unread byte |
| ovf | output | 1 | Sticky overflow flag |
| data_flag | output | 1 | Last loaded byte was data (1) or address (0) |
| start_flag | output | 1 | A Start was the last bus condition seen |
| stop_flag | output | 1 | A Stop was the last bus condition seen |
| irq | output | 1 | Interrupt request |

## Verification
A stale buffer-full or overflow flag shows up at the ninth clock of the very next byte. The acknowledge bit read back by the master flips, and rx_data either changes when it should hold or holds when it should change. A wrong shift or bit count shows up when that byte completes, as a changed rx_data value or a transmitted byte read back wrong. A lost hold release shows up as SCL stuck low, which the master sees as the bus never advancing. Start/Stop mistakes show up in start_flag, stop_flag and irq a few system clocks after the SDA edge.

// File: rtl/i2c_slv.sv
module i2c_slv (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [3:0] mode,
  input  logic [9:0] own_addr,
  input  logic [7:0] tx_data,
  input  logic       rd_buf,
  input  logic       ovf_clr,
  input  logic       irq_clr,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic [7:0] rx_data,
  output logic       buf_full,
  output logic       ovf,
  output logic       data_flag,
  output logic       start_flag,
  output logic       stop_flag,
  output logic       irq
);

  localparam logic [3:0] M_S7   = 4'b0110;
  localparam logic [3:0] M_S10  = 4'b0111;
  localparam logic [3:0] M_S7I  = 4'b1110;
  localparam logic [3:0] M_S10I = 4'b1111;
  localparam logic [3:0] M_BUS  = 4'b1011;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR2, ST_RX, ST_ACK, ST_HOLD, ST_TX, ST_TXACK, ST_WAIT
  } st_t;

  st_t        st, nxt, dec_nxt;
  logic [2:0] scl_q, sda_q, bitcnt;
  logic [7:0] sr;
  logic [6:0] txsr;
  logic       slot, ack_q, ld_q, evt_q, ovs_q, dat_q, m10;
  logic       dec_ack, dec_ld, dec_evt, dec_ovs, dec_m10;

  wire slave_on = en && (mode == M_S7 || mode == M_S10 || mode == M_S7I || mode == M_S10I);
  wire ss_irq   = en && (mode == M_S7I || mode == M_S10I || mode == M_BUS);
  wire det_on   = slave_on || ss_irq;
  wire ten      = mode[0];

  wire scl_s     = scl_q[1];
  wire sda_s     = sda_q[1];
  wire scl_rise  = scl_s & ~scl_q[2];
  wire scl_fall  = ~scl_s & scl_q[2];
  wire start_c   = scl_s & scl_q[2] & sda_q[2] & ~sda_s;
  wire stop_c    = scl_s & scl_q[2] & ~sda_q[2] & sda_s;
  wire [7:0] byte_in = {sr[6:0], sda_s};
  wire rx_ok     = !buf_full && !ovf;

  always_comb begin
    dec_ack = 1'b0;
    dec_ld  = 1'b0;
    dec_evt = 1'b0;
    dec_ovs = 1'b0;
    dec_m10 = 1'b0;
    dec_nxt = ST_WAIT;
    case (st)
      ST_ADDR: begin
        if (ten) begin
          if (byte_in[7:3] == 5'b11110 && byte_in[2:1] == own_addr[9:8]) begin
            if (!byte_in[0]) begin
              dec_ack = rx_ok;
              dec_ld  = rx_ok;
              dec_evt = 1'b1;
              dec_ovs = buf_full;
              dec_nxt = rx_ok ? ST_ADDR2 : ST_WAIT;
            end else if (m10) begin
              dec_ack = 1'b1;
              dec_evt = 1'b1;
              dec_nxt = ST_HOLD;
            end
          end
        end else if (byte_in[7:1] == own_addr[6:0] && byte_in[7:1] != 7'd0) begin
          if (!byte_in[0]) begin
            dec_ack = rx_ok;
            dec_ld  = rx_ok;
            dec_evt = 1'b1;
            dec_ovs = buf_full;
            dec_nxt = rx_ok ? ST_RX : ST_WAIT;
          end else begin
            dec_ack = 1'b1;
            dec_evt = 1'b1;
            dec_nxt = ST_HOLD;
          end
        end
      end
      ST_ADDR2: begin
        if (byte_in == own_addr[7:0]) begin
          dec_ack = rx_ok;
          dec_ld  = rx_ok;
          dec_evt = 1'b1;
          dec_ovs = buf_full;
          dec_m10 = rx_ok;
          dec_nxt = rx_ok ? ST_RX : ST_WAIT;
        end
      end
      ST_RX: begin
        dec_ack = rx_ok;
        dec_ld  = rx_ok;
        dec_evt = 1'b1;
        dec_ovs = buf_full;
        dec_nxt = ST_RX;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q      <= 3'b111;
      sda_q      <= 3'b111;
      st         <= ST_IDLE;
      nxt        <= ST_IDLE;
      bitcnt     <= 3'd0;
      sr         <= 8'd0;
      txsr       <= 7'd0;
      slot       <= 1'b0;
      ack_q      <= 1'b0;
      ld_q       <= 1'b0;
      evt_q      <= 1'b0;
      ovs_q      <= 1'b0;
      dat_q      <= 1'b0;
      m10        <= 1'b0;
      scl_oe     <= 1'b0;
      sda_oe     <= 1'b0;
      rx_data    <= 8'd0;
      buf_full   <= 1'b0;
      ovf        <= 1'b0;
      data_flag  <= 1'b0;
      start_flag <= 1'b0;
      stop_flag  <= 1'b0;
      irq        <= 1'b0;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
      if (rd_buf)  buf_full <= 1'b0;
      if (ovf_clr) ovf      <= 1'b0;
      if (irq_clr) irq      <= 1'b0;
      if (ss_irq && (start_c || stop_c)) irq <= 1'b1;
      if (det_on && start_c) begin
        start_flag <= 1'b1;
        stop_flag  <= 1'b0;
      end
      if (det_on && stop_c) begin
        stop_flag  <= 1'b1;
        start_flag <= 1'b0;
      end
      if (!slave_on) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
        scl_oe <= 1'b0;
        slot   <= 1'b0;
        m10    <= 1'b0;
      end else if (start_c) begin
        st     <= ST_ADDR;
        bitcnt <= 3'd0;
        slot   <= 1'b0;
        sda_oe <= 1'b0;
        scl_oe <= 1'b0;
      end else if (stop_c) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
        scl_oe <= 1'b0;
        m10    <= 1'b0;
      end else begin
        case (st)
          ST_ADDR, ST_ADDR2, ST_RX: begin
            if (scl_rise) begin
              sr     <= byte_in;
              bitcnt <= bitcnt + 3'd1;
              if (bitcnt == 3'd7) begin
                st    <= ST_ACK;
                ack_q <= dec_ack;
                ld_q  <= dec_ld;
                evt_q <= dec_evt;
                ovs_q <= dec_ovs;
                dat_q <= (st == ST_RX);
                nxt   <= dec_nxt;
                if (dec_m10) m10 <= 1'b1;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              if (!slot) begin
                slot   <= 1'b1;
                sda_oe <= ack_q;
              end else begin
                slot   <= 1'b0;
                sda_oe <= 1'b0;
                bitcnt <= 3'd0;
                st     <= nxt;
                if (ld_q) begin
                  rx_data   <= sr;
                  buf_full  <= 1'b1;
                  data_flag <= dat_q;
                end
                if (evt_q) irq <= 1'b1;
                if (ovs_q) ovf <= 1'b1;
                if (nxt == ST_HOLD) scl_oe <= 1'b1;
              end
            end
          end
          ST_HOLD: begin
            if (!irq) begin
              scl_oe <= 1'b0;
              txsr   <= tx_data[6:0];
              sda_oe <= ~tx_data[7];
              bitcnt <= 3'd0;
              st     <= ST_TX;
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bitcnt == 3'd7) begin
                sda_oe <= 1'b0;
                st     <= ST_TXACK;
              end else begin
                sda_oe <= ~txsr[6];
                txsr   <= {txsr[5:0], 1'b0};
                bitcnt <= bitcnt + 3'd1;
              end
            end
          end
          ST_TXACK: begin
            if (scl_rise) ack_q <= ~sda_s;
            else if (scl_fall) begin
              if (ack_q) begin
                st     <= ST_HOLD;
                scl_oe <= 1'b1;
                irq    <= 1'b1;
              end else begin
                st <= ST_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_slv_chk.sv
module i2c_slv_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       rd_buf,
  input logic       ovf_clr,
  input logic       scl_i,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       buf_full,
  input logic       ovf,
  input logic       irq,
  input logic [7:0] rx_data
);

  p_full_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full && !rd_buf |=> buf_full);

  p_keep_buf_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_data) |-> !$past(buf_full));

  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !ovf_clr |=> ovf);

  p_keep_buf_ovf_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_data) |-> !$past(ovf));

  p_hold_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_oe) && en |-> !$past(irq));

  p_sda_moves_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) && en && $past(en) |-> !scl_i);

  p_quiet_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !sda_oe && !scl_oe);

endmodule

bind i2c_slv i2c_slv_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .rd_buf(rd_buf), .ovf_clr(ovf_clr),
  .scl_i(scl_i), .scl_oe(scl_oe), .sda_oe(sda_oe), .buf_full(buf_full),
  .ovf(ovf), .irq(irq), .rx_data(rx_data)
);

// File: tb/i2c_slv_tb_top.sv
module i2c_slv_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0, en = 1'b1;
  logic [3:0] mode = 4'b0110;
  logic [9:0] own_addr = 10'h2A5;
  logic [7:0] tx_data = 8'h00;
  logic       rd_buf = 1'b0, ovf_clr = 1'b0, host_clr = 1'b0, resp_clr = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       scl_oe, sda_oe, buf_full, ovf, data_flag, start_flag, stop_flag, irq;
  logic [7:0] rx_data;
  logic       irq_clr, scl_line, sda_line;
  assign irq_clr  = host_clr | resp_clr;
  assign scl_line = scl_m & ~scl_oe;
  assign sda_line = sda_m & ~sda_oe;

  i2c_slv dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .own_addr(own_addr),
    .tx_data(tx_data), .rd_buf(rd_buf), .ovf_clr(ovf_clr), .irq_clr(irq_clr),
    .scl_i(scl_line), .sda_i(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .rx_data(rx_data), .buf_full(buf_full), .ovf(ovf), .data_flag(data_flag),
    .start_flag(start_flag), .stop_flag(stop_flag), .irq(irq)
  );

  int n_chk = 0, n_bad = 0, holds = 0, qi = 0;
  logic [7:0] txq [2];
  logic done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic q();
    repeat (20) @(negedge clk);
  endtask

  task automatic scl_up();
    scl_m = 1'b1;
    do @(negedge clk); while (!scl_line);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; q(); scl_up(); q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; q(); scl_up(); q(); sda_m = 1'b1; q();
  endtask

  task automatic wbyte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; q(); scl_up(); q(); q(); scl_m = 1'b0; q();
    end
    sda_m = 1'b1; q(); scl_up(); q(); acked = ~sda_line; q(); scl_m = 1'b0; q();
  endtask

  task automatic rbyte(input logic mack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; q(); scl_up(); q(); d[i] = sda_line; q(); scl_m = 1'b0; q();
    end
    sda_m = ~mack; q(); scl_up(); q(); q(); scl_m = 1'b0; q(); sda_m = 1'b1;
  endtask

  task automatic pulse_rd();
    @(negedge clk) rd_buf = 1'b1; @(negedge clk) rd_buf = 1'b0;
  endtask
  task automatic pulse_irq();
    @(negedge clk) host_clr = 1'b1; @(negedge clk) host_clr = 1'b0;
  endtask
  task automatic pulse_ovf();
    @(negedge clk) ovf_clr = 1'b1; @(negedge clk) ovf_clr = 1'b0;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (scl_oe) begin
        repeat (8) @(negedge clk);
        tx_data = txq[qi];
        qi++;
        resp_clr = 1'b1;
        @(negedge clk) resp_clr = 1'b0;
        while (scl_oe) @(negedge clk);
        holds++;
      end
    end
  end

  task automatic t_reset();
    chk("R1 buf_full", buf_full, 0); chk("R1 ovf", ovf, 0);
    chk("R1 data_flag", data_flag, 0); chk("R1 start_flag", start_flag, 0);
    chk("R1 stop_flag", stop_flag, 0); chk("R1 irq", irq, 0);
    chk("R1 scl_oe", scl_oe, 0); chk("R1 sda_oe", sda_oe, 0);
  endtask

  task automatic t_start_stop();
    mode = 4'b0110;
    bus_start();
    chk("R2 start sets S", start_flag, 1); chk("R2 start clears P", stop_flag, 0);
    chk("R3 no irq on start in 0110", irq, 0);
    bus_stop();
    chk("R2 stop sets P", stop_flag, 1); chk("R2 stop clears S", start_flag, 0);
    chk("R3 no irq on stop in 0110", irq, 0);
    mode = 4'b1110;
    bus_start();
    chk("R3 irq on start in 1110", irq, 1);
    pulse_irq();
    bus_stop();
    chk("R3 irq on stop in 1110", irq, 1);
    pulse_irq();
    mode = 4'b0110;
  endtask

  task automatic t_write7();
    logic a;
    bus_start();
    wbyte(8'h4A, a);
    chk("R4 address ack", a, 1); chk("R4 rx_data addr", rx_data, 8'h4A);
    chk("R4 buf_full", buf_full, 1); chk("R4 irq", irq, 1); chk("R4 data_flag", data_flag, 0);
    pulse_rd(); pulse_irq();
    chk("R5 read clears buf_full", buf_full, 0);
    wbyte(8'h3C, a);
    chk("R5 data ack", a, 1); chk("R5 rx_data", rx_data, 8'h3C);
    chk("R5 data_flag", data_flag, 1); chk("R5 irq", irq, 1);
    pulse_rd(); pulse_irq();
    wbyte(8'hA1, a);
    chk("R5 second data ack", a, 1); chk("R5 rx_data second", rx_data, 8'hA1);
    pulse_rd(); pulse_irq();
    bus_stop();
  endtask

  task automatic t_full();
    logic a;
    bus_start();
    wbyte(8'h4A, a);
    pulse_irq();
    wbyte(8'h77, a);
    chk("R6 no ack when full", a, 0); chk("R6 rx_data kept", rx_data, 8'h4A);
    chk("R6 irq still set", irq, 1); chk("R6 ovf set", ovf, 1);
    chk("R6 buf_full kept", buf_full, 1);
    pulse_irq();
    bus_stop();
  endtask

  task automatic t_ovf();
    logic a;
    pulse_rd();
    chk("R7 ovf survives read", ovf, 1); chk("R7 buf_full cleared", buf_full, 0);
    bus_start();
    wbyte(8'h4A, a);
    chk("R7 no ack on ovf", a, 0); chk("R7 irq set", irq, 1);
    chk("R7 buf_full stays 0", buf_full, 0); chk("R7 rx_data kept", rx_data, 8'h4A);
    bus_stop();
    pulse_irq(); pulse_ovf();
    chk("R7 ovf_clr clears", ovf, 0);
    bus_start();
    wbyte(8'h4A, a);
    chk("R7 ack after clear", a, 1);
    pulse_rd(); pulse_irq();
    bus_stop();
  endtask

  task automatic t_nomatch();
    logic a;
    bus_start();
    wbyte(8'h50, a);
    chk("R8 mismatch nack", a, 0); chk("R8 mismatch no irq", irq, 0); chk("R8 buf_full", buf_full, 0);
    bus_stop();
    bus_start();
    wbyte(8'h00, a);
    chk("R8 general call nack", a, 0); chk("R8 general call no irq", irq, 0);
    bus_stop();
  endtask

  task automatic t_ten();
    logic a;
    mode = 4'b0111;
    bus_start();
    wbyte(8'hF4, a);
    chk("R9 first byte ack", a, 1); chk("R9 first byte loaded", rx_data, 8'hF4);
    pulse_rd(); pulse_irq();
    wbyte(8'hA5, a);
    chk("R9 second byte ack", a, 1); chk("R9 second byte loaded", rx_data, 8'hA5);
    pulse_rd(); pulse_irq();
    wbyte(8'h11, a);
    chk("R9 data ack", a, 1); chk("R9 data loaded", rx_data, 8'h11);
    pulse_rd(); pulse_irq();
    bus_stop();
    bus_start();
    wbyte(8'hF4, a);
    pulse_rd(); pulse_irq();
    wbyte(8'hA6, a);
    chk("R9 wrong low byte nack", a, 0); chk("R9 wrong low byte no irq", irq, 0);
    chk("R9 rx_data kept", rx_data, 8'hF4);
    bus_stop();
    mode = 4'b0110;
  endtask

  task automatic t_tx();
    logic a;
    logic [7:0] d;
    txq[0] = 8'hC3; txq[1] = 8'h5A;
    bus_start();
    wbyte(8'h4B, a);
    chk("R10 read address ack", a, 1);
    rbyte(1'b1, d);
    chk("R10 first byte", d, 8'hC3);
    rbyte(1'b0, d);
    chk("R10 second byte", d, 8'h5A);
    chk("R10 two holds", holds, 2);
    q();
    chk("R10 SDA released after nack", sda_oe, 0);
    chk("R10 read address not loaded", buf_full, 0);
    bus_stop();
  endtask

  task automatic t_busonly();
    logic a;
    mode = 4'b1011;
    bus_start();
    chk("R11 irq on start", irq, 1); chk("R11 start_flag", start_flag, 1);
    pulse_irq();
    wbyte(8'h4A, a);
    chk("R11 no ack", a, 0); chk("R11 nothing loaded", buf_full, 0);
    bus_stop();
    chk("R11 irq on stop", irq, 1); chk("R11 stop_flag", stop_flag, 1);
    pulse_irq();
    mode = 4'b0110;
  endtask

  task automatic t_disabled();
    logic a;
    en = 1'b0;
    bus_start();
    chk("R12 start_flag unchanged", start_flag, 0);
    wbyte(8'h4A, a);
    chk("R12 no ack", a, 0); chk("R12 no irq", irq, 0); chk("R12 buf_full", buf_full, 0);
    bus_stop();
    en = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_start_stop();
    t_write7();
    t_full();
    t_ovf();
    t_nomatch();
    t_ten();
    t_tx();
    t_busonly();
    t_disabled();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule